// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt pin and turns activity on it into a pending flag. A small status and control register on a CPU register bus exposes that flag. Software picks one of two sensitivities. In edge mode only a falling edge latches a request. In level mode a falling edge latches a request, and so does a pin that is held low. Software can mask the request line and clear the flag by writing a one to an acknowledge bit. The request line to the interrupt arbiter is high while a request is pending and the mask is clear.

The pin is asynchronous, so it first passes through a synchroniser of `SYNC_STAGES` flops (two by default). Edges are detected on the synchronised copy. A configuration enable decides whether the pin is used as an interrupt source. When it is not, the pin still reaches the synchroniser but cannot latch a request. In level mode an acknowledge has no effect while the pin is still low, because the low level sets the flag again at once.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the pending flag, the mask and the mode are all 0, `irq_o` is 0, and a read returns 0x00.
- R2: While `rd_en_i` is 1, `rdata_o` shows the pending flag in bit 3, the mask in bit 1 and the mode in bit 0. Bits 7..4 and the acknowledge bit 2 always read 0. While `rd_en_i` is 0, `rdata_o` is 0x00.
- R3: A write with bit 2 set clears the pending flag at the next clock edge, unless a new request is latched in the same cycle. When that happens the flag stays 1.
- R4: `irq_o` equals the pending flag AND NOT the mask. A falling edge that arrives while masked still sets the pending flag, and clearing the mask then raises `irq_o`.
- R5: When the pin goes from high to low and the enable is 1, the pending flag reads 1 on the third rising clock edge after the change: two synchroniser stages, then the flag register.
- R6: In level mode (mode = 1), a pin held low keeps the pending flag at 1. An acknowledge written while the synchronised pin is low leaves it at 1.
- R7: While `pin_en_i` is 0, no edge or level on the pin sets the pending flag. A flag that is already pending can still be acknowledged.
- R8: In edge mode (mode = 0), once an acknowledge has cleared the flag, a pin that stays low does not set it again.
- R9: A write loads the mask from bit 1 and the mode from bit 0. Write data in bits 7..4 and bit 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External interrupt pin, active low, asynchronous |
| pin_en_i | input | 1 | 1 = pin acts as an interrupt source |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rdata_o | output | 8 | Register read data, 0 when not reading |
| irq_o | output | 1 | Interrupt request to the arbiter |

## Verification
The assertions assume that the write strobe and write data are stable around each rising edge. They also assume the pin is the only asynchronous input, so the enable is treated as a quasi-static synchronous signal. The bench drives every input, the pin included, on the falling clock edge, so each value is settled long before the next sampling edge. The random stimulus holds the pin at each level for several cycles and only occasionally flips the enable. This keeps the stimulus within those assumptions and still produces edges that collide with acknowledges, mask changes and mode switches.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int PEND_BIT = 3;
    localparam int ACK_BIT  = 2;
    localparam int MASK_BIT = 1;
    localparam int MODE_BIT = 0;

    typedef struct packed {
        logic pending;
        logic mask;
        logic level_mode;
    } irq_state_t;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{chain: '1};
        else         st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/extirq_edge.sv
module extirq_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic fall_o,
    output logic low_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prev: 1'b1};
        else         st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~lvl_i;
    assign low_o  = ~lvl_i;

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pin_i,
    input  logic          pin_en_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_en_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    logic pin_sync;
    logic fall_w;
    logic low_w;
    logic set_w;
    logic ack_w;

    irq_state_t st_d, st_q;

    extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    extirq_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (pin_sync),
        .fall_o (fall_w),
        .low_o  (low_w)
    );

    always_comb begin
        st_d  = st_q;
        set_w = pin_en_i & (fall_w | (st_q.level_mode & low_w));
        ack_w = wr_en_i & wdata_i[ACK_BIT];
        if (wr_en_i) begin
            st_d.mask       = wdata_i[MASK_BIT];
            st_d.level_mode = wdata_i[MODE_BIT];
        end
        if (set_w)      st_d.pending = 1'b1;
        else if (ack_w) st_d.pending = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            rdata_o[PEND_BIT] = st_q.pending;
            rdata_o[MASK_BIT] = st_q.mask;
            rdata_o[MODE_BIT] = st_q.level_mode;
        end
    end

    assign irq_o = st_q.pending & ~st_q.mask;

    AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_en_i && fall_w) |=> st_q.pending) else $error("fall lost"); // R5

    AST_LEVEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_en_i && st_q.level_mode && !pin_sync) |=> st_q.pending) else $error("level lost"); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wdata_i[ACK_BIT] && !fall_w && !(st_q.level_mode && !pin_sync)) |=> !st_q.pending)
        else $error("ack ignored"); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pin_en_i && !st_q.pending) |=> !st_q.pending) else $error("disabled set"); // R7

    AST_READ_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |-> (rdata_o[DW-1:4] == '0 && !rdata_o[ACK_BIT])) else $error("reserved bits"); // R2

    AST_MASKED_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mask && !wr_en_i && pin_en_i && fall_w) |=> (st_q.pending && !irq_o)) else $error("masked edge"); // R4

endmodule

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin, pin_en, wr_en, rd_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    extirq_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .pin_en_i(pin_en),
        .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
        .rdata_o(rdata), .irq_o(irq)
    );

    // Reference model: two sync stages, then edge history, then flag (R5)
    logic m_s1, m_s2, m_prev, m_pend, m_mask, m_mode;

    function automatic logic next_pend(logic pend, logic en, logic prev, logic s2,
                                       logic mode, logic wr, logic [7:0] wd);
        logic set;
        set = en && ((prev && !s2) || (mode && !s2));
        if (set) return 1'b1;
        if (wr && wd[2]) return 1'b0;
        return pend;
    endfunction

    function automatic logic [7:0] exp_view(logic rd, logic pend, logic mask, logic mode);
        return rd ? {4'b0, pend, 1'b0, mask, mode} : 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
            m_pend <= 1'b0; m_mask <= 1'b0; m_mode <= 1'b0;
        end else begin
            m_s1   <= pin;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_pend <= next_pend(m_pend, pin_en, m_prev, m_s2, m_mode, wr_en, wdata);
            if (wr_en) begin
                m_mask <= wdata[1];
                m_mode <= wdata[0];
            end
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        pin = 1'b1; pin_en = 1'b1; wr_en = 1'b0; rd_en = 1'b1; wdata = 8'h00;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 view", rdata, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R5 timing: flag appears on the third edge after the fall
        pin = 1'b0;
        cyc(); cyc();
        check("R5 early", rdata, 8'h00);
        cyc();
        check("R5 latched", rdata, 8'h08);
        check("R4 irq up", {7'b0, irq}, 8'h01);
        // R2 bits read zero when not reading
        rd_en = 1'b0; #0;
        check("R2 no read", rdata, 8'h00);
        rd_en = 1'b1;
        // R3/R8 ack in edge mode while pin still low
        wr(8'h04);
        check("R3 ack", rdata, 8'h00);
        cyc(); cyc();
        check("R8 no reset", rdata, 8'h00);

        // R9 write junk upper bits and bit3, set mode=1 mask=1
        pin = 1'b1; repeat (3) cyc();
        wr(8'hFB);
        check("R9 mask/mode", rdata, 8'h03);
        // R6 level mode with masked request
        pin = 1'b0; repeat (3) cyc();
        check("R6 level set", rdata, 8'h0B);
        check("R4 masked irq", {7'b0, irq}, 8'h00);
        wr(8'h07);
        check("R6 ack held", rdata, 8'h0B);
        wr(8'h01);
        check("R4 unmask", {7'b0, irq}, 8'h01);
        pin = 1'b1; repeat (3) cyc();
        wr(8'h05);
        check("R3 ack high", rdata, 8'h01);

        // R7 disabled pin
        wr(8'h00);
        pin_en = 1'b0;
        pin = 1'b0; repeat (4) cyc();
        check("R7 disabled", rdata, 8'h00);
        pin = 1'b1; repeat (3) cyc();
        pin_en = 1'b1;
        cyc();

        // Random phase: compare against model each cycle (R2, R4)
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 5 == 0) pin = ~pin;
            if ($urandom % 40 == 0) pin_en = ~pin_en;
            rd_en = ($urandom % 4) != 0;
            if ($urandom % 7 == 0) begin
                wr_en = 1'b1; wdata = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            check("R2 rand view", rdata, exp_view(rd_en, m_pend, m_mask, m_mode));
            check("R4 rand irq", {7'b0, irq}, {7'b0, m_pend & ~m_mask});
        end
        finish_run();
    end
endmodule